// File: doc/BRIEF.md
# Internal Data Memory Unit for an 8-bit Controller Core

This block holds the 256-byte internal data RAM of an 8-bit controller core and routes every data-space access to the correct storage. The core presents one access per cycle: a register operand, a direct address, an indirect address through a pointer register, or a single bit. The block turns that access into a RAM location, or passes it to the special function register (SFR) area through a separate port. The two status bits that pick the active register bank arrive on a status byte input. Reads return one clock later on a registered data output.

A stack pointer is held inside the block. Push pre-increments it and then stores. Pop reads at the current pointer and then decrements. The core can also load the pointer directly. A separate comparator marks which 16-bit external data addresses fall in the on-chip extended window, and which belong to the external bus.

Top module: `idm_top`

## Requirements
- R1: A direct access (mode code 1) with an address below 80H reads or writes the RAM byte at that address.
- R2: A direct access with an address of 80H or above goes to the SFR port (sfr_sel high, sfr_addr = address, read data taken from sfr_rdata). The RAM byte at the same index is left unchanged.
- R3: An indirect access (mode code 2) uses as its address the byte held in R0 (acc_addr[0]=0) or R1 (acc_addr[0]=1) of the bank active at that access. It reaches any of the 256 RAM bytes, including 80H–FFH, and never asserts sfr_sel.
- R4: A register access (mode code 0) to Rn, with n = acc_addr[2:0], reaches RAM address {3'b000, psw[4], psw[3], n}.
- R5: A bit access (mode code 3) with a bit address below 80H targets RAM byte 20H + addr[6:3], bit addr[2:0]. A write stores acc_wdata[0] into that bit and keeps the other seven bits. A read returns the bit in rd_data[0], with zeros above it.
- R6: A bit access with a bit address of 80H or above targets SFR byte {addr[7:3], 3'b000}. A write sends the SFR byte with only the selected bit replaced. A read returns that bit in rd_data[0].
- R7: After reset, sp is 07H and rd_data is 00H.
- R8: A push increments sp first and then writes stk_wdata at the new sp, so the first push after reset lands at 08H.
- R9: A pop loads rd_data with the byte at the current sp and then decrements sp. sp wraps modulo 256 in both directions.
- R10: xwin is high exactly when xaddr lies in F700H–FFFFH.
- R11: With no push or pop in the cycle, sp_ld loads sp with sp_ldval.
- R12: Push and pop take precedence. In a cycle with either one, the access port and sp_ld have no effect, and push wins over pop.
- R13: Read results appear on rd_data at the clock edge that accepts the access and are held until the next read or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psw | input | 8 | Status byte; bits 4:3 select the register bank |
| acc_en | input | 1 | Access request this cycle |
| acc_mode | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| acc_we | input | 1 | 1 write, 0 read |
| acc_addr | input | 8 | Register number, direct address, pointer select or bit address |
| acc_wdata | input | 8 | Write data (bit writes use bit 0) |
| rd_data | output | 8 | Registered read result |
| sfr_sel | output | 1 | Access is routed to the SFR area |
| sfr_we | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data for sfr_addr (combinational) |
| stk_push | input | 1 | Push stk_wdata |
| stk_pop | input | 1 | Pop into rd_data |
| stk_wdata | input | 8 | Push data |
| sp_ld | input | 1 | Load the stack pointer |
| sp_ldval | input | 8 | Stack pointer load value |
| sp | output | 8 | Current stack pointer |
| xaddr | input | 16 | External data address to classify |
| xwin | output | 1 | xaddr is in the on-chip extended window |

## Verification
The bench builds the block with its default parameters: reset pointer 07H, bit region base 20H, and extended window base F700H. With these values, the first push lands on R0 of bank 1, which the bench then reads back through a direct access. The bit region overlaps bytes that the direct-access vectors also write, so the bench can see a bit write preserving the other bits. The window edges F6FFH/F700H and FFFFH are reachable as concrete addresses. With an 8-bit pointer, a load of FFH is enough to exercise wrap in both directions.

// File: rtl/idm_pkg.sv
`timescale 1ns/1ps
// Shared types for the internal data memory unit.
// Assumes: access mode codes are fixed by the core's decode interface.
package idm_pkg;
    typedef enum logic [1:0] {
        AM_REG = 2'd0,
        AM_DIR = 2'd1,
        AM_IND = 2'd2,
        AM_BIT = 2'd3
    } am_t;
endpackage

// File: rtl/idm_decode.sv
`timescale 1ns/1ps
// Address decoder: turns a mode, an operand address, the active bank and the
// pointer byte into a RAM index, an SFR route flag and a bit position.
// Assumes: ptr_val is the RAM byte at ptr_idx, supplied by the caller.
module idm_decode
    import idm_pkg::*;
#(
    parameter int          AW       = 8,
    parameter logic [7:0]  BIT_BASE = 8'h20
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    bank,
    input  logic [AW-1:0] ptr_val,
    output logic [AW-1:0] ptr_idx,
    output logic [AW-1:0] ram_addr,
    output logic [AW-1:0] sfr_addr,
    output logic          to_sfr,
    output logic          bit_acc,
    output logic [2:0]    bit_pos
);
    localparam int HI = AW - 1;

    // Pointer register location: R0 or R1 of the active bank.
    always_comb begin
        ptr_idx = {{(AW-5){1'b0}}, bank, 2'b00, addr[0]};
    end

    // Resolve the target of the access from its mode.
    always_comb begin
        ram_addr = addr;
        sfr_addr = addr;
        to_sfr   = 1'b0;
        bit_acc  = 1'b0;
        bit_pos  = addr[2:0];
        unique case (am_t'(mode))
            AM_REG: ram_addr = {{(AW-5){1'b0}}, bank, addr[2:0]};
            AM_DIR: to_sfr   = addr[HI];
            AM_IND: ram_addr = ptr_val;
            AM_BIT: begin
                bit_acc  = 1'b1;
                to_sfr   = addr[HI];
                ram_addr = BIT_BASE + {{(AW-4){1'b0}}, addr[HI-1:3]};
                sfr_addr = {addr[HI:3], 3'b000};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/idm_stack.sv
`timescale 1ns/1ps
// Stack pointer: pre-increment on push, post-decrement on pop, direct load.
// Assumes: push beats pop, and both beat a load; arithmetic wraps at 2**AW.
module idm_stack #(
    parameter int          AW       = 8,
    parameter logic [7:0]  SP_RESET = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          ld,
    input  logic [AW-1:0] ldval,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_up
);
    // Address a push will write to.
    always_comb sp_up = sp + AW'(1);

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= SP_RESET;
        else if (push) sp <= sp_up;
        else if (pop)  sp <= sp - AW'(1);
        else if (ld)   sp <= ldval;
    end

    // R7
    sp_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sp == SP_RESET);
    // R8
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp == $past(sp) + AW'(1));
    // R9
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> sp == $past(sp) - AW'(1));
    // R11
    sp_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !push && !pop) |=> sp == $past(ldval));
endmodule

// File: rtl/idm_xwin.sv
`timescale 1ns/1ps
// External window detector: flags 16-bit data addresses at or above BASE.
// Assumes: the window runs from BASE to the top of the address space.
module idm_xwin #(
    parameter int           XW   = 16,
    parameter logic [15:0]  BASE = 16'hF700
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] xaddr,
    output logic          hit
);
    // Range compare against the window base.
    always_comb hit = (xaddr >= XW'(BASE));

    // R10
    xwin_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(xaddr) |-> $stable(hit));
endmodule

// File: rtl/idm_top.sv
`timescale 1ns/1ps
// Internal data memory unit: 256-byte RAM, bank-relative registers, bit
// access, stack and SFR routing. One access or stack operation per cycle.
// Assumes: sfr_rdata is valid combinationally for sfr_addr in the same cycle.
module idm_top
    import idm_pkg::*;
#(
    parameter int           AW        = 8,
    parameter int           DW        = 8,
    parameter logic [7:0]   SP_RESET  = 8'h07,
    parameter logic [7:0]   BIT_BASE  = 8'h20,
    parameter int           XW        = 16,
    parameter logic [15:0]  XWIN_BASE = 16'hF700
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    psw,
    input  logic          acc_en,
    input  logic [1:0]    acc_mode,
    input  logic          acc_we,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] rd_data,
    output logic          sfr_sel,
    output logic          sfr_we,
    output logic [AW-1:0] sfr_addr,
    output logic [DW-1:0] sfr_wdata,
    input  logic [DW-1:0] sfr_rdata,
    input  logic          stk_push,
    input  logic          stk_pop,
    input  logic [DW-1:0] stk_wdata,
    input  logic          sp_ld,
    input  logic [AW-1:0] sp_ldval,
    output logic [AW-1:0] sp,
    input  logic [XW-1:0] xaddr,
    output logic          xwin
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr_idx, ram_addr, sp_up;
    logic [DW-1:0] ptr_val, ram_rd, bmask, ram_bitw, ram_wval;
    logic          to_sfr, bit_acc, acc_go, ram_we, stk_busy;
    logic [2:0]    bit_pos;
    logic [1:0]    bank;

    assign bank = psw[4:3];

    idm_decode #(.AW(AW), .BIT_BASE(BIT_BASE)) i_dec (
        .mode(acc_mode), .addr(acc_addr), .bank(bank), .ptr_val(ptr_val),
        .ptr_idx(ptr_idx), .ram_addr(ram_addr), .sfr_addr(sfr_addr),
        .to_sfr(to_sfr), .bit_acc(bit_acc), .bit_pos(bit_pos)
    );

    idm_stack #(.AW(AW), .SP_RESET(SP_RESET)) i_stk (
        .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
        .ld(sp_ld), .ldval(sp_ldval), .sp(sp), .sp_up(sp_up)
    );

    idm_xwin #(.XW(XW), .BASE(XWIN_BASE)) i_xw (
        .clk(clk), .rst_n(rst_n), .xaddr(xaddr), .hit(xwin)
    );

    // RAM read ports for the pointer and the access target.
    always_comb begin
        ptr_val = mem[ptr_idx];
        ram_rd  = mem[ram_addr];
    end

    // Gate the access, build bit-merge values and SFR strobes.
    always_comb begin
        stk_busy  = stk_push || stk_pop;
        acc_go    = acc_en && !stk_busy;
        bmask     = DW'(1) << bit_pos;
        ram_bitw  = acc_wdata[0] ? (ram_rd | bmask) : (ram_rd & ~bmask);
        ram_wval  = bit_acc ? ram_bitw : acc_wdata;
        ram_we    = acc_go && acc_we && !to_sfr;
        sfr_sel   = acc_go && to_sfr;
        sfr_we    = sfr_sel && acc_we;
        if (bit_acc)
            sfr_wdata = acc_wdata[0] ? (sfr_rdata | bmask) : (sfr_rdata & ~bmask);
        else
            sfr_wdata = acc_wdata;
    end

    // RAM writes: push first, then access writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (stk_push) begin
            mem[sp_up] <= stk_wdata;
        end else if (ram_we) begin
            mem[ram_addr] <= ram_wval;
        end
    end

    // Registered read result from pop, RAM or SFR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (stk_pop && !stk_push) begin
            rd_data <= mem[sp];
        end else if (acc_go && !acc_we) begin
            if (to_sfr)
                rd_data <= bit_acc ? DW'(sfr_rdata[bit_pos]) : sfr_rdata;
            else
                rd_data <= bit_acc ? DW'(ram_rd[bit_pos]) : ram_rd;
        end
    end

    // R3
    ind_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode == 2'd2) |-> !sfr_sel);
    // R2
    sfr_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && acc_mode == 2'd1) |=> mem[$past(acc_addr)] == $past(mem[acc_addr]));
    // R5
    bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && bit_acc) |=>
            ((mem[$past(ram_addr)] ^ $past(ram_rd)) & ~$past(bmask)) == '0);
    // R4
    reg_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && acc_we && acc_mode == 2'd0) |=>
            mem[{3'b000, $past(psw[4:3]), $past(acc_addr[2:0])}] == $past(acc_wdata));
endmodule

// File: tb/test_idm_top.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walked by one loop, then directed
// stack, precedence, reset and window tests.
module test_idm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  psw = '0;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_mode = '0;
    logic        acc_we = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  rd_data;
    logic        sfr_sel, sfr_we;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
    logic        stk_push = 1'b0, stk_pop = 1'b0, sp_ld = 1'b0;
    logic [7:0]  stk_wdata = '0, sp_ldval = '0;
    logic [7:0]  sp;
    logic [15:0] xaddr = '0;
    logic        xwin;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    idm_top i_idm_top (
        .clk(clk), .rst_n(rst_n), .psw(psw), .acc_en(acc_en),
        .acc_mode(acc_mode), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .rd_data(rd_data), .sfr_sel(sfr_sel),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .stk_push(stk_push), .stk_pop(stk_pop),
        .stk_wdata(stk_wdata), .sp_ld(sp_ld), .sp_ldval(sp_ldval), .sp(sp),
        .xaddr(xaddr), .xwin(xwin)
    );

    // SFR area model seen by the block.
    logic [7:0] sfr_m [128];
    initial for (int i = 0; i < 128; i++) sfr_m[i] = '0;
    assign sfr_rdata = sfr_m[sfr_addr[6:0]];
    always @(posedge clk) if (sfr_we) sfr_m[sfr_addr[6:0]] <= sfr_wdata;

    // {req, bank, mode, we, addr, wdata, expected}
    localparam int NV = 27;
    localparam logic [32:0] VEC [NV] = '{
        {4'd1,  2'd0, 2'd1, 1'b1, 8'h30, 8'hA5, 8'h00}, // R1 write
        {4'd1,  2'd0, 2'd1, 1'b0, 8'h30, 8'h00, 8'hA5}, // R1 read
        {4'd4,  2'd0, 2'd0, 1'b1, 8'h03, 8'h11, 8'h00}, // R4 bank0 R3
        {4'd4,  2'd2, 2'd0, 1'b1, 8'h03, 8'h22, 8'h00}, // R4 bank2 R3
        {4'd4,  2'd0, 2'd1, 1'b0, 8'h03, 8'h00, 8'h11}, // R4
        {4'd4,  2'd0, 2'd1, 1'b0, 8'h13, 8'h00, 8'h22}, // R4
        {4'd4,  2'd2, 2'd0, 1'b0, 8'h03, 8'h00, 8'h22}, // R4
        {4'd4,  2'd3, 2'd0, 1'b1, 8'h07, 8'hE1, 8'h00}, // R4 bank3 R7
        {4'd4,  2'd0, 2'd1, 1'b0, 8'h1F, 8'h00, 8'hE1}, // R4
        {4'd3,  2'd1, 2'd0, 1'b1, 8'h00, 8'hC0, 8'h00}, // R3 bank1 R0=C0
        {4'd3,  2'd1, 2'd2, 1'b1, 8'h00, 8'h5A, 8'h00}, // R3 @R0
        {4'd3,  2'd1, 2'd2, 1'b0, 8'h00, 8'h00, 8'h5A}, // R3 upper RAM
        {4'd3,  2'd1, 2'd0, 1'b1, 8'h01, 8'h2F, 8'h00}, // R3 R1=2F
        {4'd3,  2'd1, 2'd2, 1'b1, 8'h01, 8'h66, 8'h00}, // R3 @R1
        {4'd3,  2'd0, 2'd1, 1'b0, 8'h2F, 8'h00, 8'h66}, // R3
        {4'd2,  2'd0, 2'd1, 1'b1, 8'h90, 8'h77, 8'h00}, // R2 SFR write
        {4'd2,  2'd0, 2'd1, 1'b1, 8'hC0, 8'h33, 8'h00}, // R2 SFR write
        {4'd2,  2'd1, 2'd2, 1'b0, 8'h00, 8'h00, 8'h5A}, // R2 RAM C0 kept
        {4'd2,  2'd0, 2'd1, 1'b0, 8'hC0, 8'h00, 8'h33}, // R2 SFR read
        {4'd5,  2'd0, 2'd1, 1'b1, 8'h21, 8'h0F, 8'h00}, // R5 seed byte
        {4'd5,  2'd0, 2'd3, 1'b1, 8'h0F, 8'h01, 8'h00}, // R5 set bit 7
        {4'd5,  2'd0, 2'd1, 1'b0, 8'h21, 8'h00, 8'h8F}, // R5
        {4'd5,  2'd0, 2'd3, 1'b0, 8'h0B, 8'h00, 8'h01}, // R5 read bit 3
        {4'd5,  2'd0, 2'd3, 1'b1, 8'h09, 8'h00, 8'h00}, // R5 clear bit 1
        {4'd5,  2'd0, 2'd1, 1'b0, 8'h21, 8'h00, 8'h8D}, // R5
        {4'd6,  2'd0, 2'd3, 1'b1, 8'h93, 8'h01, 8'h00}, // R6 SFR 90 bit3
        {4'd6,  2'd0, 2'd1, 1'b0, 8'h90, 8'h00, 8'h7F}  // R6
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] bank, input logic [1:0] mode,
                       input logic we, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        psw = {3'b000, bank, 3'b000};
        acc_en = 1'b1; acc_mode = mode; acc_we = we; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic stk(input logic push, input logic pop, input logic [7:0] d);
        @(negedge clk);
        stk_push = push; stk_pop = pop; stk_wdata = d;
        @(negedge clk);
        stk_push = 1'b0; stk_pop = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R7 sp after reset", sp, 8'h07);
        chk("R7 rd_data after reset", rd_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][28:27], VEC[i][26:25], VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
            if (!VEC[i][24])
                chk($sformatf("R%0d vector %0d", VEC[i][32:29], i), rd_data, VEC[i][7:0]);
        end
        acc(2'd0, 2'd3, 1'b0, 8'h96, 8'h00);
        chk("R6 SFR bit 6 read", rd_data, 8'h01);
        acc(2'd0, 2'd3, 1'b0, 8'h97, 8'h00);
        chk("R6 SFR bit 7 read", rd_data, 8'h00);
        chk("R13 read held while idle", rd_data, 8'h00);

        stk(1'b1, 1'b0, 8'hAB);
        chk("R8 first push sp", sp, 8'h08);
        acc(2'd0, 2'd1, 1'b0, 8'h08, 8'h00);
        chk("R8 first push lands at 08", rd_data, 8'hAB);
        stk(1'b1, 1'b0, 8'hCD);
        chk("R8 second push sp", sp, 8'h09);
        stk(1'b0, 1'b1, 8'h00);
        chk("R9 pop data", rd_data, 8'hCD);
        chk("R9 pop sp", sp, 8'h08);

        @(negedge clk); sp_ld = 1'b1; sp_ldval = 8'hFF;
        @(negedge clk); sp_ld = 1'b0;
        chk("R11 sp load", sp, 8'hFF);
        stk(1'b1, 1'b0, 8'h11);
        chk("R9 push wraps sp", sp, 8'h00);
        acc(2'd0, 2'd1, 1'b0, 8'h00, 8'h00);
        chk("R9 wrapped push data", rd_data, 8'h11);
        stk(1'b0, 1'b1, 8'h00);
        chk("R9 pop wrap data", rd_data, 8'h11);
        chk("R9 pop wraps sp", sp, 8'hFF);

        // R12: push with a write and a load in the same cycle.
        @(negedge clk);
        stk_push = 1'b1; stk_wdata = 8'h44;
        acc_en = 1'b1; acc_mode = 2'd1; acc_we = 1'b1; acc_addr = 8'h40; acc_wdata = 8'h99;
        sp_ld = 1'b1; sp_ldval = 8'h55;
        @(negedge clk);
        stk_push = 1'b0; acc_en = 1'b0; acc_we = 1'b0; sp_ld = 1'b0;
        chk("R12 push beats load", sp, 8'h00);
        acc(2'd0, 2'd1, 1'b0, 8'h40, 8'h00);
        chk("R12 access write suppressed", rd_data, 8'h00);
        acc(2'd0, 2'd1, 1'b0, 8'h00, 8'h00);
        chk("R12 push data written", rd_data, 8'h44);
        // R12: push beats pop.
        stk(1'b1, 1'b1, 8'h66);
        chk("R12 push beats pop sp", sp, 8'h01);
        chk("R12 pop suppressed rd_data", rd_data, 8'h44);

        xaddr = 16'hF6FF; #1 chk("R10 F6FF outside", {7'b0, xwin}, 8'h00);
        xaddr = 16'hF700; #1 chk("R10 F700 inside", {7'b0, xwin}, 8'h01);
        xaddr = 16'hFFFF; #1 chk("R10 FFFF inside", {7'b0, xwin}, 8'h01);
        xaddr = 16'h0000; #1 chk("R10 0000 outside", {7'b0, xwin}, 8'h00);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R7 sp after second reset", sp, 8'h07);
        chk("R7 rd_data after second reset", rd_data, 8'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule